// File: doc/BRIEF.md
# Trigger and Broadcast Channel Encoder

This block produces one serial timing stream that interleaves two logical channels. Each bunch crossing takes two clock cycles. The first cycle carries the channel-A bit, which is the first-level accept/reject decision for that crossing, passed through with one register of latency. The second cycle carries the next bit of channel B. Channel B transmits framed, Hamming-protected broadcast messages. When no frame is in flight it rests at logic 1.

Five sources request broadcasts, each on its own request/acknowledge pair:

- bunch-counter reset
- event-ID reset
- second-level trigger decision word
- front-end command word (resets, calibration pulses)
- destination-address long broadcast

The first four are sent as 16-bit short frames. The fifth is sent as a 42-bit long frame carrying a receiver address, a sub-address and a data byte. A fixed-priority arbiter chooses among the pending requests whenever the channel-B serializer is free. A frame, once begun, is always sent in full.

Top module: `trig_bcast_encoder`

## Requirements
- R1: While rst_n is low, line_is_b and line_bit are both 1 and every acknowledge output stays 0, even when requests are asserted.
- R2: After reset, line_is_b is 0 on the first cycle and then toggles every cycle. On a cycle where line_is_b is 0, line_bit equals trig_accept as sampled at the preceding clock edge.
- R3: On a channel-B cycle with no frame in progress, line_bit is 1.
- R4: A short frame is 16 channel-B bits, sent in this order: 0 (start), 0 (format), the 8 data bits MSB first, 5 check bits, 1 (stop). The data byte depends on the source:
  - bunch-counter reset sends 8'h01 (parameter)
  - event-ID reset sends 8'h02 (parameter)
  - a decision sends dec_word
  - a front-end command sends fec_word
- R5: Short check bits use 4 Hamming bits plus 1 parity bit, computed as follows.
  - Data bit j (bit 0 is the LSB) is placed at the (j+1)-th integer of 3 or more that is not a power of two.
  - Hamming bit i is the XOR of the data bits whose position has bit i set.
  - The parity bit is the XOR of all data bits and all Hamming bits.
  - The 5 check bits are sent parity first, then Hamming bits 3 down to 0.
- R6: A long frame is 42 channel-B bits, sent in this order: 0, 1, then a 32-bit payload MSB first, then 7 check bits, then 1. The payload is {dst_node[13:0], dst_ext, 1'b1, dst_sub[7:0], dst_data[7:0]}.
- R7: Long check bits follow the rule of R5 applied to the 32 payload bits, giving 6 Hamming bits plus 1 parity bit. They are sent parity first, then Hamming bits 5 down to 0.
- R8: When several requests are pending at a frame start, exactly one is granted. The order from highest priority is: bunch-counter reset, event-ID reset, decision, front-end command, destination broadcast.
- R9: A frame in progress is never interrupted. A new frame starts only after the previous stop bit has been sent, and it may start in the very next channel-B slot.
- R10: An acknowledge is a single-cycle pulse. It is asserted only while its request is high, in the cycle just before that frame's start bit appears. A request stays pending until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, two cycles per crossing |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_accept | input | 1 | First-level accept/reject for the current crossing |
| bcr_req | input | 1 | Bunch-counter reset request |
| bcr_ack | output | 1 | Bunch-counter reset acknowledge |
| ecr_req | input | 1 | Event-ID reset request |
| ecr_ack | output | 1 | Event-ID reset acknowledge |
| dec_req | input | 1 | Second-level decision request |
| dec_word | input | 8 | Decision byte |
| dec_ack | output | 1 | Decision acknowledge |
| fec_req | input | 1 | Front-end command request |
| fec_word | input | 8 | Front-end command byte |
| fec_ack | output | 1 | Front-end command acknowledge |
| dst_req | input | 1 | Destination-address broadcast request |
| dst_node | input | 14 | Receiver address field |
| dst_ext | input | 1 | Flag bit of the long frame |
| dst_sub | input | 8 | Sub-address field |
| dst_data | input | 8 | Long-frame data byte |
| dst_ack | output | 1 | Destination broadcast acknowledge |
| line_bit | output | 1 | Serial stream bit |
| line_is_b | output | 1 | High when line_bit belongs to channel B |

## Verification
The hardest condition to reach is contention that arrives while a 42-bit long frame is still being shifted out. It must be shown that the waiting sources neither cut the frame short nor lose their place in the priority order.

The stimulus starts a destination broadcast and waits for its acknowledge. While the frame is still on the line, it raises a lower-priority decision and a higher-priority bunch-counter reset. It then checks that the bit stream stays intact and that both waiting frames follow back to back in priority order. A second pass re-requests the long frame in the cycle after its acknowledge to exercise two long frames sent back to back.

// File: rtl/tbe_pkg.sv
`timescale 1ns/1ps
// Package: shared widths, source identifiers and the Hamming check
// generator used by the trigger/broadcast encoder.
// Assumes payloads are zero-extended to LP_W before check generation.
package tbe_pkg;
    localparam int SD_W  = 8;                  // short data width
    localparam int SC_W  = 5;                  // short check width
    localparam int LA_W  = 14;                 // long address width
    localparam int LS_W  = 8;                  // long sub-address width
    localparam int LD_W  = 8;                  // long data width
    localparam int LP_W  = LA_W + 2 + LS_W + LD_W; // long payload width
    localparam int LC_W  = 7;                  // long check width
    localparam int S_LEN = SD_W + SC_W + 3;    // short frame length
    localparam int L_LEN = LP_W + LC_W + 3;    // long frame length
    localparam int FR_W  = L_LEN;              // frame buffer width
    localparam int CNT_W = $clog2(L_LEN + 1);
    localparam int N_SRC = 5;
    localparam int SRC_W = 3;
    localparam int IDX_W = $clog2(LP_W);

    typedef enum logic [SRC_W-1:0] {
        SRC_BCR = 3'd0,
        SRC_ECR = 3'd1,
        SRC_DEC = 3'd2,
        SRC_FEC = 3'd3,
        SRC_DST = 3'd4
    } src_e;

    // Returns nc Hamming bits in [nc-1:0] and overall parity in [nc].
    function automatic logic [LC_W-1:0] ham_chk(input logic [LP_W-1:0] d,
                                                input int nd, input int nc);
        logic [LC_W-1:0] r;
        int j;
        r = '0;
        j = 0;
        for (int p = 3; p < 64; p++) begin
            if (((p & (p - 1)) != 0) && (j < nd)) begin
                for (int i = 0; i < LC_W - 1; i++) begin
                    if ((i < nc) && (((p >> i) & 1) == 1))
                        r[i] = r[i] ^ d[j[IDX_W-1:0]];
                end
                j++;
            end
        end
        r[nc[2:0]] = (^d) ^ (^r);
        return r;
    endfunction
endpackage

// File: rtl/tbe_prio_arb.sv
`timescale 1ns/1ps
// Fixed-priority arbiter: index 0 wins. Grants only while en is high.
// Assumes requests are held until granted; clk/rst_n serve the checks.
module tbe_prio_arb #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [N-1:0] req,
    output logic [N-1:0] grant
);
    // One grant term per requester, masked by all higher-priority ones.
    for (genvar g = 0; g < N; g++) begin : g_slot
        if (g == 0) begin : g_top
            assign grant[g] = en & req[g];
        end else begin : g_rest
            assign grant[g] = en & req[g] & ~(|req[g-1:0]);
        end
    end

    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8
    AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (grant & ~req) == '0); // R10
    AST_GRANT_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |-> en); // R9
endmodule

// File: rtl/tbe_frame_build.sv
`timescale 1ns/1ps
// Frame builder: forms the left-justified frame and its length for the
// selected source, with Hamming check bits. Purely combinational.
// Assumes source fields are stable in the cycle the frame is loaded.
module tbe_frame_build
    import tbe_pkg::*;
#(
    parameter logic [SD_W-1:0] BCR_CODE = 8'h01,
    parameter logic [SD_W-1:0] ECR_CODE = 8'h02
) (
    input  src_e             sel,
    input  logic [SD_W-1:0]  dec_word,
    input  logic [SD_W-1:0]  fec_word,
    input  logic [LA_W-1:0]  dst_node,
    input  logic             dst_ext,
    input  logic [LS_W-1:0]  dst_sub,
    input  logic [LD_W-1:0]  dst_data,
    output logic [FR_W-1:0]  frame,
    output logic [CNT_W-1:0] flen
);
    logic [SD_W-1:0] sdat;
    logic [LP_W-1:0] payload;
    logic [LC_W-1:0] schk;
    logic [LC_W-1:0] lchk;

    // Pick the short-frame data byte for the granted source.
    always_comb begin
        case (sel)
            SRC_BCR: sdat = BCR_CODE;
            SRC_ECR: sdat = ECR_CODE;
            SRC_DEC: sdat = dec_word;
            SRC_FEC: sdat = fec_word;
            default: sdat = '0;
        endcase
    end

    assign payload = {dst_node, dst_ext, 1'b1, dst_sub, dst_data};

    // Compute both check fields.
    always_comb begin
        schk = ham_chk({{(LP_W-SD_W){1'b0}}, sdat}, SD_W, SC_W - 1);
        lchk = ham_chk(payload, LP_W, LC_W - 1);
    end

    // Assemble the frame for the selected format, MSB sent first.
    always_comb begin
        if (sel == SRC_DST) begin
            frame = {1'b0, 1'b1, payload, lchk, 1'b1};
            flen  = CNT_W'(L_LEN);
        end else begin
            frame = {2'b00, sdat, schk[SC_W-1:0], 1'b1, {(FR_W-S_LEN){1'b0}}};
            flen  = CNT_W'(S_LEN);
        end
    end
endmodule

// File: rtl/tbe_line_mux.sv
`timescale 1ns/1ps
// Line multiplexer: alternates channel-A and channel-B slots on one
// serial output and shifts out loaded frames on the B slots.
// Assumes load is raised only while free is high.
module tbe_line_mux
    import tbe_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_accept,
    input  logic             load,
    input  logic [FR_W-1:0]  frame,
    input  logic [CNT_W-1:0] flen,
    output logic             free,
    output logic             line_bit,
    output logic             line_is_b
);
    logic             ph;
    logic [FR_W-1:0]  sh;
    logic [CNT_W-1:0] left;

    assign free = ph && (left == '0);

    // Slot sequencing, channel-A pass-through and channel-B shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph        <= 1'b0;
            line_bit  <= 1'b1;
            line_is_b <= 1'b1;
            sh        <= '0;
            left      <= '0;
        end else begin
            ph <= ~ph;
            if (!ph) begin
                line_bit  <= trig_accept;
                line_is_b <= 1'b0;
            end else begin
                line_is_b <= 1'b1;
                if (load) begin
                    line_bit <= frame[FR_W-1];
                    sh       <= frame << 1;
                    left     <= flen - 1'b1;
                end else if (left != '0) begin
                    line_bit <= sh[FR_W-1];
                    sh       <= sh << 1;
                    left     <= left - 1'b1;
                end else begin
                    line_bit <= 1'b1;
                end
            end
        end
    end

    AST_A_SLOT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !line_is_b |-> (line_bit == $past(trig_accept))); // R2
    AST_B_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (ph && (left == '0) && !load) |=> line_bit); // R3
    AST_LEFT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        left <= CNT_W'(L_LEN - 1)); // R6
endmodule

// File: rtl/trig_bcast_encoder.sv
`timescale 1ns/1ps
// Trigger and broadcast channel encoder (top). Merges the per-crossing
// accept bit with prioritised short/long broadcast frames on one line.
// Assumes requesters hold req and data stable until acknowledged.
module trig_bcast_encoder
    import tbe_pkg::*;
#(
    parameter logic [SD_W-1:0] BCR_CODE = 8'h01,
    parameter logic [SD_W-1:0] ECR_CODE = 8'h02
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            trig_accept,
    input  logic            bcr_req,
    output logic            bcr_ack,
    input  logic            ecr_req,
    output logic            ecr_ack,
    input  logic            dec_req,
    input  logic [SD_W-1:0] dec_word,
    output logic            dec_ack,
    input  logic            fec_req,
    input  logic [SD_W-1:0] fec_word,
    output logic            fec_ack,
    input  logic            dst_req,
    input  logic [LA_W-1:0] dst_node,
    input  logic            dst_ext,
    input  logic [LS_W-1:0] dst_sub,
    input  logic [LD_W-1:0] dst_data,
    output logic            dst_ack,
    output logic            line_bit,
    output logic            line_is_b
);
    logic [N_SRC-1:0] req_vec;
    logic [N_SRC-1:0] grant;
    logic             free;
    src_e             sel;
    logic [FR_W-1:0]  frame;
    logic [CNT_W-1:0] flen;

    assign req_vec = {dst_req, fec_req, dec_req, ecr_req, bcr_req};

    tbe_prio_arb #(.N(N_SRC)) u_arb (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (free),
        .req   (req_vec),
        .grant (grant)
    );

    // Encode the one-hot grant into a source identifier.
    always_comb begin
        sel = SRC_BCR;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (grant[i]) sel = src_e'(i[SRC_W-1:0]);
        end
    end

    assign bcr_ack = grant[SRC_BCR];
    assign ecr_ack = grant[SRC_ECR];
    assign dec_ack = grant[SRC_DEC];
    assign fec_ack = grant[SRC_FEC];
    assign dst_ack = grant[SRC_DST];

    tbe_frame_build #(.BCR_CODE(BCR_CODE), .ECR_CODE(ECR_CODE)) u_build (
        .sel      (sel),
        .dec_word (dec_word),
        .fec_word (fec_word),
        .dst_node (dst_node),
        .dst_ext  (dst_ext),
        .dst_sub  (dst_sub),
        .dst_data (dst_data),
        .frame    (frame),
        .flen     (flen)
    );

    tbe_line_mux u_line (
        .clk         (clk),
        .rst_n       (rst_n),
        .trig_accept (trig_accept),
        .load        (|grant),
        .frame       (frame),
        .flen        (flen),
        .free        (free),
        .line_bit    (line_bit),
        .line_is_b   (line_is_b)
    );

    AST_BCR_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        bcr_ack |=> !bcr_ack); // R10
    AST_DST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        dst_ack |=> !dst_ack); // R10
    AST_ACK_ON_B_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (|grant) |=> line_is_b && !line_bit); // R9
endmodule

// File: tb/test_trig_bcast_encoder.sv
`timescale 1ns/1ps
module test_trig_bcast_encoder;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig_accept = 1'b0;
    logic bcr_req = 1'b0, ecr_req = 1'b0, dec_req = 1'b0, fec_req = 1'b0, dst_req = 1'b0;
    logic [7:0] dec_word = 8'h00, fec_word = 8'h00, dst_sub = 8'h00, dst_data = 8'h00;
    logic [13:0] dst_node = 14'h0;
    logic dst_ext = 1'b0;
    logic bcr_ack, ecr_ack, dec_ack, fec_ack, dst_ack, line_bit, line_is_b;

    trig_bcast_encoder i_trig_bcast_encoder (
        .clk(clk), .rst_n(rst_n), .trig_accept(trig_accept),
        .bcr_req(bcr_req), .bcr_ack(bcr_ack),
        .ecr_req(ecr_req), .ecr_ack(ecr_ack),
        .dec_req(dec_req), .dec_word(dec_word), .dec_ack(dec_ack),
        .fec_req(fec_req), .fec_word(fec_word), .fec_ack(fec_ack),
        .dst_req(dst_req), .dst_node(dst_node), .dst_ext(dst_ext),
        .dst_sub(dst_sub), .dst_data(dst_data), .dst_ack(dst_ack),
        .line_bit(line_bit), .line_is_b(line_is_b)
    );

    always #5 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    bit exp_bit[$];
    int exp_tag[$];
    int ack_log[$];
    int exp_order[$];
    logic last_acc = 1'b0;
    bit prev_b = 1'b1;
    int cyc = 0;

    function automatic string tname(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            7: return "R7";
            8: return "R8";
            9: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(bit ok, int tag, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tname(tag), act, expv, $time);
        end
    endtask

    // Reference check bits from the rule in R5/R7.
    function automatic logic [6:0] ref_ham(logic [31:0] d, int nd, int nc);
        int pos[32];
        int p;
        logic [6:0] r;
        logic par;
        p = 2;
        for (int j = 0; j < nd; j++) begin
            p++;
            while ((p & (p - 1)) == 0) p++;
            pos[j] = p;
        end
        r = '0;
        for (int i = 0; i < nc; i++)
            for (int j = 0; j < nd; j++)
                if (((pos[j] >> i) & 1) == 1) r[i] = r[i] ^ d[j];
        par = 1'b0;
        for (int j = 0; j < nd; j++) par = par ^ d[j];
        for (int i = 0; i < nc; i++) par = par ^ r[i];
        r[nc] = par;
        return r;
    endfunction

    task automatic push(bit b, int tag);
        exp_bit.push_back(b);
        exp_tag.push_back(tag);
    endtask

    // Expected short frame bits, R4 structure and R5 checks.
    task automatic push_short(logic [7:0] d);
        logic [6:0] r;
        r = ref_ham({24'h0, d}, 8, 4);
        push(1'b0, 4); push(1'b0, 4);
        for (int i = 7; i >= 0; i--) push(d[i], 4);
        for (int i = 4; i >= 0; i--) push(r[i], 5);
        push(1'b1, 4);
    endtask

    // Expected long frame bits, R6 structure and R7 checks.
    task automatic push_long();
        logic [31:0] pl;
        logic [6:0] r;
        pl = {dst_node, dst_ext, 1'b1, dst_sub, dst_data};
        r = ref_ham(pl, 32, 6);
        push(1'b0, 6); push(1'b1, 6);
        for (int i = 31; i >= 0; i--) push(pl[i], 6);
        for (int i = 6; i >= 0; i--) push(r[i], 7);
        push(1'b1, 6);
    endtask

    // Channel-A stimulus pattern.
    always @(negedge clk) begin
        cyc <= cyc + 1;
        trig_accept <= cyc[0] ^ cyc[2] ^ cyc[3];
    end

    always @(posedge clk) last_acc <= trig_accept;

    // Driver side of the scoreboard: each acknowledge pushes its frame.
    always @(posedge clk) begin
        if (rst_n) begin
            check($countones({bcr_ack, ecr_ack, dec_ack, fec_ack, dst_ack}) <= 1, 8,
                  {bcr_ack, ecr_ack, dec_ack, fec_ack, dst_ack}, 0);
            if (bcr_ack || ecr_ack || dec_ack || fec_ack || dst_ack)
                check(exp_bit.size() == 0, 9, exp_bit.size(), 0); // R9 no overlap
            if (bcr_ack) begin
                check(bcr_req, 10, bcr_req, 1);
                push_short(8'h01); ack_log.push_back(0); bcr_req <= 1'b0;
            end
            if (ecr_ack) begin
                check(ecr_req, 10, ecr_req, 1);
                push_short(8'h02); ack_log.push_back(1); ecr_req <= 1'b0;
            end
            if (dec_ack) begin
                check(dec_req, 10, dec_req, 1);
                push_short(dec_word); ack_log.push_back(2); dec_req <= 1'b0;
            end
            if (fec_ack) begin
                check(fec_req, 10, fec_req, 1);
                push_short(fec_word); ack_log.push_back(3); fec_req <= 1'b0;
            end
            if (dst_ack) begin
                check(dst_req, 10, dst_req, 1);
                push_long(); ack_log.push_back(4); dst_req <= 1'b0;
            end
        end
    end

    // Monitor side: compares every line bit against the expectation.
    always @(negedge clk) begin
        bit b;
        int t;
        if (!rst_n) begin
            prev_b = 1'b1;
        end else begin
            check(line_is_b != prev_b, 2, line_is_b, !prev_b);
            prev_b = line_is_b;
            if (!line_is_b) begin
                check(line_bit == last_acc, 2, line_bit, last_acc);
            end else if (exp_bit.size() > 0) begin
                b = exp_bit.pop_front();
                t = exp_tag.pop_front();
                check(line_bit == b, t, line_bit, b);
            end else begin
                check(line_bit == 1'b1, 3, line_bit, 1); // R3 idle
            end
        end
    end

    task automatic drain();
        @(negedge clk);
        while (bcr_req || ecr_req || dec_req || fec_req || dst_req || exp_bit.size() > 0)
            @(negedge clk);
        repeat (4) @(negedge clk);
    endtask

    // R8: compare the observed acknowledge order with the expected one.
    task automatic check_order();
        check(ack_log.size() == exp_order.size(), 8, ack_log.size(), exp_order.size());
        for (int i = 0; i < exp_order.size() && i < ack_log.size(); i++)
            check(ack_log[i] == exp_order[i], 8, ack_log[i], exp_order[i]);
        ack_log.delete();
        exp_order.delete();
    endtask

    initial begin
        // R1: reset state, with a request asserted during reset.
        @(negedge clk);
        bcr_req <= 1'b1;
        repeat (3) begin
            @(negedge clk);
            check(line_is_b && line_bit, 1, {line_is_b, line_bit}, 3);
            check({bcr_ack, ecr_ack, dec_ack, fec_ack, dst_ack} == 5'b0, 1,
                  {bcr_ack, ecr_ack, dec_ack, fec_ack, dst_ack}, 0);
        end
        rst_n <= 1'b1;
        exp_order.push_back(0);
        drain(); check_order();
        repeat (20) @(negedge clk); // R2/R3 idle run

        ecr_req <= 1'b1; exp_order.push_back(1);
        drain(); check_order();

        dec_word <= 8'hA5; dec_req <= 1'b1; exp_order.push_back(2);
        drain(); check_order();
        fec_word <= 8'h3C; fec_req <= 1'b1; exp_order.push_back(3);
        drain(); check_order();

        // R6/R7 single long frame.
        dst_node <= 14'h2AB5; dst_ext <= 1'b1; dst_sub <= 8'h5A; dst_data <= 8'hC3;
        dst_req <= 1'b1; exp_order.push_back(4);
        drain(); check_order();

        // R8: all five contend at once.
        dec_word <= 8'h81; fec_word <= 8'h7E;
        dst_node <= 14'h0F0F; dst_ext <= 1'b0; dst_sub <= 8'h11; dst_data <= 8'hEE;
        bcr_req <= 1'b1; ecr_req <= 1'b1; dec_req <= 1'b1; fec_req <= 1'b1; dst_req <= 1'b1;
        exp_order.push_back(0); exp_order.push_back(1); exp_order.push_back(2);
        exp_order.push_back(3); exp_order.push_back(4);
        drain(); check_order();

        // R9: higher-priority requests raised during a long frame wait.
        dst_node <= 14'h3FFF; dst_ext <= 1'b1; dst_sub <= 8'h00; dst_data <= 8'hFF;
        dst_req <= 1'b1;
        @(negedge clk);
        while (dst_req) @(negedge clk);
        repeat (10) @(negedge clk);
        dec_word <= 8'h42; dec_req <= 1'b1; bcr_req <= 1'b1;
        exp_order.push_back(4); exp_order.push_back(0); exp_order.push_back(2);
        drain(); check_order();

        // R4/R5 corner bytes with R8 ordering.
        dec_word <= 8'h00; fec_word <= 8'hFF;
        fec_req <= 1'b1; dec_req <= 1'b1; ecr_req <= 1'b1;
        exp_order.push_back(1); exp_order.push_back(2); exp_order.push_back(3);
        drain(); check_order();

        // R9/R10: two long frames back to back.
        dst_node <= 14'h1234; dst_ext <= 1'b0; dst_sub <= 8'hA0; dst_data <= 8'h05;
        dst_req <= 1'b1;
        @(negedge clk);
        while (dst_req) @(negedge clk);
        dst_node <= 14'h0001; dst_ext <= 1'b1; dst_sub <= 8'hFE; dst_data <= 8'h80;
        dst_req <= 1'b1;
        exp_order.push_back(4); exp_order.push_back(4);
        drain(); check_order();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1000000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule